// File: doc/BRIEF.md
# Segmented Carry-Chain Arithmetic Cluster

This block is a 20-bit arithmetic slice. It is built from ten two-bit cells joined by a dedicated carry path. Each cell resolves its two bits by carry-select: it forms both candidate results in advance, and the incoming carry only picks one of them. This splits the ripple delay into two-bit steps. The slice adds, subtracts, or counts. It gives a combinational sum, a registered sum and a carry-out. The carry-out can feed the carry-in of a following cluster to build longer chains.

A span control selects the cells that take part. The chain can use all ten cells. It can use only the lower five cells, so that its carry continues into the lower half of the next cluster. It can also start at the middle cell and use only the upper five. In counter mode the registered sum is fed back as operand A, and operand B is replaced by plus or minus one. The register updates under a clock enable. A synchronous clear acts only while the clock enable is high. The count advances only while a separate counter enable is also high.

Top module: `arith_cluster`

## Requirements
- R1: With span code 0 (full) in add mode, sum_c equals (a_in + b_in + carry_in) mod 2^20, and carry_out is bit 20 of that total.
- R2: With subtract=1 and count_mode=0, the active span computes a_in + ~b_in + 1. carry_in has no effect, and carry_out is 1 exactly when the active field of a_in is not below that of b_in.
- R3: With span code 1 (lower), only bits 9:0 are computed. sum_c[19:10] reads 0, and carry_out is the carry out of bit 9.
- R4: With span code 2 (upper), the chain starts at bit 10 and takes carry_in there. sum_c[9:0] reads 0, and carry_out is the carry out of bit 19. Span code 3 behaves as span code 0.
- R5: On a rising clock edge with clk_en=1 and sync_clr=0 outside counter mode, sum_q loads sum_c. With clk_en=0, sum_q holds whatever the other inputs are.
- R6: sync_clr=1 with clk_en=1 clears sum_q on the next edge. sync_clr=1 with clk_en=0 leaves sum_q unchanged.
- R7: With count_mode=1, sum_c is sum_q plus one (count_up=1) or minus one (count_up=0) over the active span. a_in, b_in, carry_in and subtract are ignored. sum_q advances only on an edge where clk_en=1 and count_en=1.
- R8: When counting up from all ones in the active span, the result wraps to 0 with carry_out=1. When counting down from 0, it wraps to all ones with carry_out=0.
- R9: rst_n=0 clears sum_q at once, without a clock. The release is synchronised over two clock edges, and the register does not update during those edges.
- R10: Two clusters in lower span, with the first's carry_out driving the second's carry_in, produce the 20-bit sum of their concatenated 10-bit operand fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 20 | Operand A |
| b_in | input | 20 | Operand B |
| carry_in | input | 1 | Carry into the chain start in add mode |
| span | input | 2 | 0 full, 1 lower five cells, 2 upper five cells, 3 as full |
| subtract | input | 1 | 1 selects A minus B |
| count_mode | input | 1 | 1 selects counter operation on sum_q |
| count_up | input | 1 | Counter direction, 1 counts up |
| count_en | input | 1 | Counter advance enable |
| clk_en | input | 1 | Register clock enable |
| sync_clr | input | 1 | Synchronous clear, acts while clk_en is high |
| sum_q | output | 20 | Registered sum |
| sum_c | output | 20 | Combinational sum, masked to the active span |
| carry_out | output | 1 | Carry out of the last active cell |

## Verification
The assertions assume that every control input is a defined 0 or 1 at each rising edge after reset release. They also assume that the span code does not change in the cycle it is sampled, so that the registered value can be compared with the combinational result of the previous cycle. The bench changes all inputs only on the falling edge. It draws random operands, modes and enables, and adds directed runs of all-ones, zero and wraparound values, so these assumptions always hold.

// File: rtl/arith_cluster_pkg.sv
package arith_cluster_pkg;
  typedef enum logic [1:0] {
    SPAN_FULL  = 2'd0,
    SPAN_LOWER = 2'd1,
    SPAN_UPPER = 2'd2,
    SPAN_ALT   = 2'd3
  } span_e;
endpackage

// File: rtl/ac_cell.sv
// Carry-select cell: both candidate sums are formed ahead of the carry.
module ac_cell #(
  parameter int BITS = 2
) (
  input  logic [BITS-1:0] a,
  input  logic [BITS-1:0] b,
  input  logic            cin,
  output logic [BITS-1:0] s,
  output logic            cout
);
  logic [BITS:0] cand0;
  logic [BITS:0] cand1;

  always_comb begin
    cand0 = {1'b0, a} + {1'b0, b};
    cand1 = {1'b0, a} + {1'b0, b} + {{BITS{1'b0}}, 1'b1};
    s     = cin ? cand1[BITS-1:0] : cand0[BITS-1:0];
    cout  = cin ? cand1[BITS]     : cand0[BITS];
  end
endmodule

// File: rtl/ac_chain.sv
module ac_chain #(
  parameter int CELLS = 10,
  parameter int BITS  = 2,
  localparam int W    = CELLS * BITS,
  localparam int MID  = CELLS / 2
) (
  input  logic [W-1:0]     a_eff,
  input  logic [W-1:0]     b_eff,
  input  logic             cin_lo,
  input  logic             cin_mid,
  input  logic             mid_start,
  output logic [W-1:0]     sum,
  output logic [CELLS-1:0] carry
);
  logic [CELLS-1:0] cell_cin;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    if (i == 0) begin : g_first
      assign cell_cin[i] = cin_lo;
    end else if (i == MID) begin : g_mid
      assign cell_cin[i] = mid_start ? cin_mid : carry[i-1];
    end else begin : g_link
      assign cell_cin[i] = carry[i-1];
    end

    ac_cell #(.BITS(BITS)) u_cell (
      .a    (a_eff[i*BITS +: BITS]),
      .b    (b_eff[i*BITS +: BITS]),
      .cin  (cell_cin[i]),
      .s    (sum[i*BITS +: BITS]),
      .cout (carry[i])
    );
  end
endmodule

// File: rtl/ac_operand.sv
module ac_operand
  import arith_cluster_pkg::*;
#(
  parameter int W = 20,
  localparam int HALF = W / 2
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] acc,
  input  logic         carry_in,
  input  span_e        span,
  input  logic         subtract,
  input  logic         count_mode,
  input  logic         count_up,
  output logic [W-1:0] a_eff,
  output logic [W-1:0] b_eff,
  output logic         cin_eff,
  output logic [W-1:0] mask
);
  localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] LOW_M = (ONE << HALF) - ONE;

  logic [W-1:0] unit;

  always_comb begin
    unique case (span)
      SPAN_LOWER: begin mask = LOW_M;  unit = ONE;         end
      SPAN_UPPER: begin mask = ~LOW_M; unit = ONE << HALF; end
      default:    begin mask = '1;     unit = ONE;         end
    endcase

    if (count_mode) begin
      a_eff   = acc;
      b_eff   = count_up ? unit : '1;
      cin_eff = 1'b0;
    end else if (subtract) begin
      a_eff   = a_in;
      b_eff   = ~b_in;
      cin_eff = 1'b1;
    end else begin
      a_eff   = a_in;
      b_eff   = b_in;
      cin_eff = carry_in;
    end
  end
endmodule

// File: rtl/arith_cluster.sv
module arith_cluster
  import arith_cluster_pkg::*;
#(
  parameter int CELLS = 10,
  parameter int BITS  = 2,
  localparam int W    = CELLS * BITS,
  localparam int MID  = CELLS / 2,
  localparam int HALF = MID * BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         carry_in,
  input  logic [1:0]   span,
  input  logic         subtract,
  input  logic         count_mode,
  input  logic         count_up,
  input  logic         count_en,
  input  logic         clk_en,
  input  logic         sync_clr,
  output logic [W-1:0] sum_q,
  output logic [W-1:0] sum_c,
  output logic         carry_out
);
  span_e            span_sel;
  logic [1:0]       rst_pipe;
  logic             rst_lcl_n;
  logic [W-1:0]     a_eff, b_eff, mask, raw_sum, sum_d;
  logic             cin_eff, mid_start;
  logic [CELLS-1:0] carry;

  assign span_sel  = span_e'(span);
  assign mid_start = (span_sel == SPAN_UPPER);

  // Reset: asserted asynchronously, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_lcl_n = rst_pipe[1];

  ac_operand #(.W(W)) u_operand (
    .a_in       (a_in),
    .b_in       (b_in),
    .acc        (sum_q),
    .carry_in   (carry_in),
    .span       (span_sel),
    .subtract   (subtract),
    .count_mode (count_mode),
    .count_up   (count_up),
    .a_eff      (a_eff),
    .b_eff      (b_eff),
    .cin_eff    (cin_eff),
    .mask       (mask)
  );

  ac_chain #(.CELLS(CELLS), .BITS(BITS)) u_chain (
    .a_eff     (a_eff),
    .b_eff     (b_eff),
    .cin_lo    (cin_eff),
    .cin_mid   (cin_eff),
    .mid_start (mid_start),
    .sum       (raw_sum),
    .carry     (carry)
  );

  always_comb begin
    sum_c     = raw_sum & mask;
    carry_out = (span_sel == SPAN_LOWER) ? carry[MID-1] : carry[CELLS-1];
  end

  // Next-state: clock enable outranks clear; counting needs count_en too
  always_comb begin
    sum_d = sum_q;
    if (clk_en) begin
      if (sync_clr)                  sum_d = '0;
      else if (!count_mode || count_en) sum_d = sum_c;
    end
  end

  always_ff @(posedge clk or negedge rst_lcl_n) begin
    if (!rst_lcl_n) sum_q <= '0;
    else            sum_q <= sum_d;
  end

  // R5: no enable, no change
  a_r5_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_lcl_n)
    !clk_en |=> $stable(sum_q));

  // R5: plain load captures the combinational result
  a_r5_load_from_chain: assert property (@(posedge clk) disable iff (!rst_lcl_n)
    (clk_en && !sync_clr && !count_mode) |=> (sum_q == $past(sum_c)));

  // R6: clear under enable
  a_r6_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_lcl_n)
    (clk_en && sync_clr) |=> (sum_q == '0));

  // R7: counter paused by count_en
  a_r7_count_pause: assert property (@(posedge clk) disable iff (!rst_lcl_n)
    (clk_en && !sync_clr && count_mode && !count_en) |=> $stable(sum_q));

  // R3: lower span never loads upper bits
  a_r3_lower_span_upper_zero: assert property (@(posedge clk) disable iff (!rst_lcl_n)
    (clk_en && !sync_clr && !count_mode && span_sel == SPAN_LOWER)
      |=> (sum_q[W-1:HALF] == '0));

  // R4: upper span never loads lower bits
  a_r4_upper_span_lower_zero: assert property (@(posedge clk) disable iff (!rst_lcl_n)
    (clk_en && !sync_clr && !count_mode && span_sel == SPAN_UPPER)
      |=> (sum_q[HALF-1:0] == '0));
endmodule

// File: tb/arith_cluster_test.sv
module arith_cluster_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b_in;
  logic carry_in, subtract, count_mode, count_up, count_en, clk_en, sync_clr;
  logic [1:0] span;
  logic [W-1:0] sum_q, sum_c;
  logic carry_out;

  // cascade pair (R10)
  logic [W-1:0] ca_lo, cb_lo, ca_hi, cb_hi;
  logic [W-1:0] cs_lo, cs_hi, cq_lo, cq_hi;
  logic cc_in, cc_mid, cc_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] model_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  arith_cluster uut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .carry_in(carry_in),
    .span(span), .subtract(subtract), .count_mode(count_mode), .count_up(count_up),
    .count_en(count_en), .clk_en(clk_en), .sync_clr(sync_clr),
    .sum_q(sum_q), .sum_c(sum_c), .carry_out(carry_out));

  arith_cluster uut_lo (
    .clk(clk), .rst_n(rst_n), .a_in(ca_lo), .b_in(cb_lo), .carry_in(cc_in),
    .span(2'd1), .subtract(1'b0), .count_mode(1'b0), .count_up(1'b0),
    .count_en(1'b0), .clk_en(1'b0), .sync_clr(1'b0),
    .sum_q(cq_lo), .sum_c(cs_lo), .carry_out(cc_mid));

  arith_cluster uut_hi (
    .clk(clk), .rst_n(rst_n), .a_in(ca_hi), .b_in(cb_hi), .carry_in(cc_mid),
    .span(2'd1), .subtract(1'b0), .count_mode(1'b0), .count_up(1'b0),
    .count_en(1'b0), .clk_en(1'b0), .sync_clr(1'b0),
    .sum_q(cq_hi), .sum_c(cs_hi), .carry_out(cc_out));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference: {carry, sum} over the active span
  function automatic logic [W:0] ref_calc(
    input logic [W-1:0] a, input logic [W-1:0] b, input logic cin,
    input logic [1:0] sp, input logic sub, input logic cm, input logic up,
    input logic [W-1:0] q);
    int n, off;
    logic [31:0] fmask, fa, fb, fc, tot;
    n   = (sp == 2'd1 || sp == 2'd2) ? 10 : 20;
    off = (sp == 2'd2) ? 10 : 0;
    fmask = (32'd1 << n) - 32'd1;
    fa = cm ? ((32'(q) >> off) & fmask) : ((32'(a) >> off) & fmask);
    if (cm)       fb = up ? 32'd1 : fmask;
    else if (sub) fb = (~(32'(b) >> off)) & fmask;
    else          fb = (32'(b) >> off) & fmask;
    fc  = cm ? 32'd0 : (sub ? 32'd1 : {31'd0, cin});
    tot = fa + fb + fc;
    ref_calc = {tot[n], W'((tot & fmask) << off)};
  endfunction

  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic cin,
    input logic [1:0] sp, input logic sub, input logic cm, input logic up,
    input logic cen, input logic ce, input logic clr, input string req);
    logic [W:0] e;
    @(negedge clk);
    a_in = a; b_in = b; carry_in = cin; span = sp; subtract = sub;
    count_mode = cm; count_up = up; count_en = cen; clk_en = ce; sync_clr = clr;
    #1;
    e = ref_calc(a, b, cin, sp, sub, cm, up, model_q);
    check(32'(sum_c), 32'(e[W-1:0]), req);
    check({31'd0, carry_out}, {31'd0, e[W]}, req);
    if (ce) begin
      if (clr) model_q = '0;
      else if (!cm || cen) model_q = e[W-1:0];
    end
    @(posedge clk); #1;
    check(32'(sum_q), 32'(model_q), req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; a_in = '0; b_in = '0; carry_in = 0; span = 0; subtract = 0;
    count_mode = 0; count_up = 0; count_en = 0; clk_en = 0; sync_clr = 0;
    ca_lo = '0; cb_lo = '0; ca_hi = '0; cb_hi = '0; cc_in = 0;
    model_q = '0;
    repeat (3) @(posedge clk);
    #1 check(32'(sum_q), 32'd0, "R9 reset state");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 directed
    step(20'hFFFFF, 20'h00001, 1'b0, 2'd0, 0, 0, 0, 0, 1, 0, "R1 all-ones wrap");
    step(20'h12345, 20'h0ABCD, 1'b1, 2'd0, 0, 0, 0, 0, 1, 0, "R1 add with carry");
    // R2
    step(20'h00010, 20'h00010, 1'b0, 2'd0, 1, 0, 0, 0, 1, 0, "R2 equal no borrow");
    step(20'h00001, 20'h00002, 1'b1, 2'd0, 1, 0, 0, 0, 1, 0, "R2 borrow cin ignored");
    // R3 / R4
    step(20'hFFFFF, 20'h00001, 1'b0, 2'd1, 0, 0, 0, 0, 1, 0, "R3 lower span wrap");
    step(20'hFFFFF, 20'h00400, 1'b1, 2'd2, 0, 0, 0, 0, 1, 0, "R4 upper span carry");
    step(20'h3FFFF, 20'h0C000, 1'b0, 2'd3, 0, 0, 0, 0, 1, 0, "R4 code 3 as full");
    // R5 / R6
    step(20'h11111, 20'h22222, 1'b0, 2'd0, 0, 0, 0, 0, 0, 0, "R5 hold no enable");
    step(20'h11111, 20'h22222, 1'b0, 2'd0, 0, 0, 0, 0, 0, 1, "R6 clear ignored");
    step(20'h11111, 20'h22222, 1'b0, 2'd0, 0, 0, 0, 0, 1, 1, "R6 clear applied");
    // R7 / R8 counters
    step(20'hFFFFF, 20'h00000, 1'b0, 2'd0, 0, 0, 0, 0, 1, 0, "R8 preload ones");
    step(20'h12345, 20'h54321, 1'b1, 2'd0, 1, 1, 1, 1, 1, 0, "R8 up wrap");
    step(20'h12345, 20'h54321, 1'b1, 2'd0, 0, 1, 0, 1, 1, 0, "R8 down wrap");
    step(20'h0, 20'h0, 1'b0, 2'd0, 0, 1, 0, 0, 1, 0, "R7 pause count_en");
    step(20'h0, 20'h0, 1'b0, 2'd2, 0, 1, 1, 1, 1, 0, "R7 upper count");
    step(20'h0, 20'h0, 1'b0, 2'd1, 0, 1, 0, 1, 1, 0, "R7 lower down");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      if (i % 37 == 0) ra = '1;
      if (i % 41 == 0) rb = '1;
      step(ra, rb, 1'($urandom), 2'($urandom), 1'($urandom), ($urandom % 4) == 0,
           1'($urandom), 1'($urandom), ($urandom % 4) != 0, ($urandom % 8) == 0,
           "R1 R2 R3 R4 R5 R6 R7 random");
    end

    // R9 asynchronous reset mid-run
    step(20'h5A5A5, 20'h0, 1'b0, 2'd0, 0, 0, 0, 0, 1, 0, "R9 preload");
    @(negedge clk); clk_en = 0; #2; rst_n = 1'b0; #1;
    check(32'(sum_q), 32'd0, "R9 async clear");
    model_q = '0;
    @(negedge clk); rst_n = 1'b1; a_in = 20'h00777; b_in = 0; subtract = 0;
    count_mode = 0; span = 0; clk_en = 1; sync_clr = 0;
    @(posedge clk); #1 check(32'(sum_q), 32'd0, "R9 held during sync edge 1");
    @(posedge clk); #1 check(32'(sum_q), 32'd0, "R9 held during sync edge 2");
    @(posedge clk); #1 check(32'(sum_q), 32'h00777, "R9 runs after sync");
    clk_en = 0;

    // R10 cascade of two lower-span clusters
    for (int i = 0; i < 100; i++) begin
      logic [19:0] x, y;
      logic [20:0] t;
      logic ci;
      x = (i == 0) ? 20'hFFFFF : 20'($urandom);
      y = (i == 0) ? 20'h00000 : 20'($urandom);
      ci = (i == 0) ? 1'b1 : 1'($urandom);
      @(negedge clk);
      ca_lo = {10'd0, x[9:0]};  cb_lo = {10'd0, y[9:0]};
      ca_hi = {10'd0, x[19:10]}; cb_hi = {10'd0, y[19:10]};
      cc_in = ci;
      #1;
      t = {1'b0, x} + {1'b0, y} + {20'd0, ci};
      check({11'd0, cc_out, cs_hi[9:0], cs_lo[9:0]}, {11'd0, t}, "R10 cascade");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule